// File: doc/BRIEF.md
# ASID Ring-Matched Translation Lookup

This block translates a 32-bit virtual address through a set-associative translation table and decides whether the access may proceed. Every way has its own fixed page size. The address bits just above that page size pick one candidate entry in each way. A candidate hits when three things hold: its tag equals the address above the page offset, its address-space identifier is nonzero, and that identifier appears in the ring register. The ring register holds four 8-bit identifiers, one for each privilege ring. The privilege ring of a hit is the position of the matching byte in that register. Entries carry no privilege field of their own.

The caller presents the table contents that match the lookup kind (instruction table for fetches, data table for loads and stores) on a flat bus, along with the request. The result appears on registered outputs one cycle after the request. It is either a physical address with a permission mask and cache mode, or a fault cause code. Fault precedence is multi-hit, then miss, then privilege, then access denial. The ring register is written through a dedicated write strobe.

Top module: `tlbx_lookup`

## Requirements
- R1: On reset the ring register holds 0x04030201, so identifier 1 maps to ring 0, identifier 2 to ring 1, identifier 3 to ring 2 and identifier 4 to ring 3.
- R2: A ring register write takes effect for lookups issued from the next cycle on; a lookup issued in the same cycle as the write sees the old value. The ring register holds its value when no write occurs. When several bytes equal an entry's identifier, the lowest byte position (bits 7:0 is ring 0) gives the ring.
- R3: A candidate whose identifier is zero, or whose identifier matches no byte of the ring register, never hits, even if its tag matches.
- R4: If two or more ways hit, the cause is 2 for a fetch and 6 for a data access. This takes precedence over every other cause.
- R5: If no way hits, the cause is 1 for a fetch and 5 for a data access.
- R6: If the single hit's ring is numerically lower than the requested privilege ring, the cause is 3 for a fetch and 7 for a data access.
- R7: Attribute values 0..11 grant read; attribute bit 0 grants execute and bit 1 grants write. Attribute bits 3:2 select the cache mode: 0 gives bypass (code 1), 1 gives write-back (code 2), 2 gives write-through (code 3). Attribute 13 grants read and write with isolate mode (code 4). Any other attribute grants nothing, with mode code 0. The permission output is {execute, write, read} in bits 2:0.
- R8: Fetch lookups (kind 2) lose read and write permission. Data lookups (kind 0 load, kind 1 store, kind 3 reserved) lose execute permission.
- R9: When the required permission is missing, the cause is 8 for a load, 9 for a store and 4 for a fetch. Kind 3 is never granted and reports 8.
- R10: Way w has a page of PAGE_MIN + w*PAGE_STEP offset bits, and the index is taken from the bits directly above the offset. On success the physical address is the entry's physical base ORed with the virtual address bits below the page size.
- R11: The response is registered: rsp_valid follows req_valid by one cycle. rsp_ok is 1 exactly when the cause is 0. On any fault the physical address, permission, cache mode, way and ring outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rasid_we | input | 1 | Ring register write strobe |
| rasid_wdata | input | 32 | Ring register write value, byte r is the identifier of ring r |
| req_valid | input | 1 | Lookup request |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_priv | input | 2 | Requested privilege ring |
| req_vaddr | input | 32 | Virtual address |
| tlb_entries | input | NUM_WAYS*ENTRIES*76 | Entry k = way*ENTRIES+index at bits [k*76 +: 76], fields from MSB: tag 32, physical base 32, identifier 8, attribute 4 |
| rsp_valid | output | 1 | Response valid |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_cause | output | 4 | Fault cause, 0 on success |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | {execute, write, read} after kind masking |
| rsp_cache | output | 3 | Cache mode code |
| rsp_way | output | clog2(NUM_WAYS) | Hitting way |
| rsp_ring | output | 2 | Ring of the hit |

## Verification
Random tables are generated so that each candidate matches the address about half the time. Identifiers are drawn from zero, the four reset identifiers and arbitrary values. Across lookups this yields misses, single hits and multi-hits in mixed proportion, and the random attribute, kind and privilege values together separate the four fault classes from each other and from success. A second random phase loads ring registers with repeated and zero bytes, which distinguishes lowest-position ring selection and the zero-identifier rule from naive matching. Directed cases fix each cause code for both fetch and data lookups, the same-cycle ring write, the widest page way, and every cache-mode code.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int ATTR_W  = 4;
    localparam int RINGS   = 4;
    localparam int RING_W  = 2;
    localparam int RASID_W = RINGS * ASID_W;

    localparam logic [RASID_W-1:0] RASID_RESET = 32'h0403_0201;

    typedef struct packed {
        logic [VA_W-1:0]   tag;
        logic [VA_W-1:0]   pbase;
        logic [ASID_W-1:0] asid;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    localparam int ENTRY_W = $bits(tlb_entry_t);

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [3:0] {
        CAUSE_NONE        = 4'd0,
        CAUSE_FETCH_MISS  = 4'd1,
        CAUSE_FETCH_MULTI = 4'd2,
        CAUSE_FETCH_PRIV  = 4'd3,
        CAUSE_FETCH_DENY  = 4'd4,
        CAUSE_DATA_MISS   = 4'd5,
        CAUSE_DATA_MULTI  = 4'd6,
        CAUSE_DATA_PRIV   = 4'd7,
        CAUSE_LOAD_DENY   = 4'd8,
        CAUSE_STORE_DENY  = 4'd9
    } cause_e;

    typedef enum logic [2:0] {
        CM_NONE    = 3'd0,
        CM_BYPASS  = 3'd1,
        CM_WBACK   = 3'd2,
        CM_WTHRU   = 3'd3,
        CM_ISOLATE = 3'd4
    } cache_mode_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        perm_t       perm;
        cache_mode_e cm;
    } attr_dec_t;

    // Mask of the page offset bits for a page of 'bits' offset bits.
    function automatic logic [VA_W-1:0] low_mask(input int bits);
        logic [VA_W-1:0] m;
        m = '0;
        for (int i = 0; i < VA_W; i++) begin
            if (i < bits) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Raw attribute decode, before the lookup kind strips permissions.
    function automatic attr_dec_t decode_attr(input logic [ATTR_W-1:0] a);
        attr_dec_t d;
        d.perm = '0;
        d.cm   = CM_NONE;
        if (a < 4'd12) begin
            d.perm.r = 1'b1;
            d.perm.x = a[0];
            d.perm.w = a[1];
            case (a[3:2])
                2'd0:    d.cm = CM_BYPASS;
                2'd1:    d.cm = CM_WBACK;
                default: d.cm = CM_WTHRU;
            endcase
        end else if (a == 4'd13) begin
            d.perm.r = 1'b1;
            d.perm.w = 1'b1;
            d.cm     = CM_ISOLATE;
        end
        return d;
    endfunction

endpackage

// File: rtl/tlbx_way_probe.sv
module tlbx_way_probe
    import tlbx_pkg::*;
#(
    parameter int ENTRIES   = 4,
    parameter int PAGE_BITS = 12
) (
    input  logic [VA_W-1:0]            vaddr,
    input  logic [ENTRIES*ENTRY_W-1:0] way_entries,
    input  logic [RASID_W-1:0]         rasid,
    output logic                       hit,
    output logic [RING_W-1:0]          ring,
    output tlb_entry_t                 cand
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [VA_W-1:0] OFFS_MASK = low_mask(PAGE_BITS);

    logic [IDX_W-1:0] idx;
    logic             tag_ok;
    logic             ring_found;

    generate
        if (ENTRIES > 1) begin : g_idx
            assign idx = vaddr[PAGE_BITS +: IDX_W];
        end else begin : g_single
            assign idx = '0;
        end
    endgenerate

    assign cand   = tlb_entry_t'(way_entries[idx*ENTRY_W +: ENTRY_W]);
    assign tag_ok = ((cand.tag ^ vaddr) & ~OFFS_MASK) == '0;

    // Lowest matching byte position wins, so scan from the top down.
    always_comb begin
        ring_found = 1'b0;
        ring       = '0;
        for (int r = RINGS - 1; r >= 0; r--) begin
            if (rasid[r*ASID_W +: ASID_W] == cand.asid) begin
                ring_found = 1'b1;
                ring       = RING_W'(r);
            end
        end
    end

    assign hit = tag_ok && (cand.asid != '0) && ring_found;

endmodule

// File: rtl/tlbx_hit_merge.sv
module tlbx_hit_merge
    import tlbx_pkg::*;
#(
    parameter int NUM_WAYS  = 4,
    parameter int PAGE_MIN  = 12,
    parameter int PAGE_STEP = 2,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0]        hit_vec,
    input  logic [NUM_WAYS*RING_W-1:0] way_ring,
    input  tlb_entry_t                 way_cand [NUM_WAYS],
    output logic                       any_hit,
    output logic                       multi_hit,
    output logic [WAY_W-1:0]           sel_way,
    output logic [RING_W-1:0]          sel_ring,
    output tlb_entry_t                 sel_entry,
    output logic [VA_W-1:0]            sel_offs_mask
);

    always_comb begin
        sel_way   = '0;
        sel_ring  = '0;
        sel_entry = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                sel_way   = WAY_W'(w);
                sel_ring  = way_ring[w*RING_W +: RING_W];
                sel_entry = way_cand[w];
            end
        end
    end

    assign any_hit       = |hit_vec;
    assign multi_hit     = $countones(hit_vec) > 1;
    assign sel_offs_mask = low_mask(PAGE_MIN + int'(sel_way) * PAGE_STEP);

endmodule

// File: rtl/tlbx_perm_check.sv
module tlbx_perm_check
    import tlbx_pkg::*;
(
    input  logic              any_hit,
    input  logic              multi_hit,
    input  acc_kind_e         kind,
    input  logic [RING_W-1:0] priv,
    input  logic [RING_W-1:0] ring,
    input  tlb_entry_t        entry,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [VA_W-1:0]   offs_mask,
    output logic              ok,
    output cause_e            cause,
    output logic [VA_W-1:0]   paddr,
    output perm_t             perm,
    output cache_mode_e       cache
);

    attr_dec_t dec;
    perm_t     eff;
    logic      is_fetch;
    logic      granted;

    assign is_fetch = (kind == ACC_FETCH);
    assign dec      = decode_attr(entry.attr);

    always_comb begin
        eff = dec.perm;
        if (is_fetch) begin
            eff.r = 1'b0;
            eff.w = 1'b0;
        end else begin
            eff.x = 1'b0;
        end
    end

    always_comb begin
        case (kind)
            ACC_LOAD:  granted = eff.r;
            ACC_STORE: granted = eff.w;
            ACC_FETCH: granted = eff.x;
            default:   granted = 1'b0;
        endcase
    end

    always_comb begin
        cause = CAUSE_NONE;
        if (multi_hit) begin
            cause = is_fetch ? CAUSE_FETCH_MULTI : CAUSE_DATA_MULTI;
        end else if (!any_hit) begin
            cause = is_fetch ? CAUSE_FETCH_MISS : CAUSE_DATA_MISS;
        end else if (ring < priv) begin
            cause = is_fetch ? CAUSE_FETCH_PRIV : CAUSE_DATA_PRIV;
        end else if (!granted) begin
            case (kind)
                ACC_FETCH: cause = CAUSE_FETCH_DENY;
                ACC_STORE: cause = CAUSE_STORE_DENY;
                default:   cause = CAUSE_LOAD_DENY;
            endcase
        end
    end

    assign ok    = (cause == CAUSE_NONE);
    assign paddr = ok ? (entry.pbase | (vaddr & offs_mask)) : '0;
    assign perm  = ok ? eff : '0;
    assign cache = ok ? dec.cm : CM_NONE;

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
    import tlbx_pkg::*;
#(
    parameter int NUM_WAYS  = 4,
    parameter int ENTRIES   = 4,
    parameter int PAGE_MIN  = 12,
    parameter int PAGE_STEP = 2,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int WAY_BITS = ENTRIES * ENTRY_W,
    localparam int TBL_W    = NUM_WAYS * WAY_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rasid_we,
    input  logic [31:0]      rasid_wdata,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [1:0]       req_priv,
    input  logic [31:0]      req_vaddr,
    input  logic [TBL_W-1:0] tlb_entries,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [3:0]       rsp_cause,
    output logic [31:0]      rsp_paddr,
    output logic [2:0]       rsp_perm,
    output logic [2:0]       rsp_cache,
    output logic [WAY_W-1:0] rsp_way,
    output logic [1:0]       rsp_ring
);

    logic [RASID_W-1:0]         rasid_q;
    logic [NUM_WAYS-1:0]        hit_vec;
    logic [NUM_WAYS*RING_W-1:0] way_ring;
    tlb_entry_t                 way_cand [NUM_WAYS];

    logic              any_hit;
    logic              multi_hit;
    logic [WAY_W-1:0]  sel_way;
    logic [RING_W-1:0] sel_ring;
    tlb_entry_t        sel_entry;
    logic [VA_W-1:0]   sel_offs_mask;

    logic              chk_ok;
    cause_e            chk_cause;
    logic [VA_W-1:0]   chk_paddr;
    perm_t             chk_perm;
    cache_mode_e       chk_cache;

    always_ff @(posedge clk) begin
        if (rst) begin
            rasid_q <= RASID_RESET;
        end else if (rasid_we) begin
            rasid_q <= rasid_wdata;
        end
    end

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            tlbx_way_probe #(
                .ENTRIES  (ENTRIES),
                .PAGE_BITS(PAGE_MIN + w * PAGE_STEP)
            ) u_probe (
                .vaddr      (req_vaddr),
                .way_entries(tlb_entries[w*WAY_BITS +: WAY_BITS]),
                .rasid      (rasid_q),
                .hit        (hit_vec[w]),
                .ring       (way_ring[w*RING_W +: RING_W]),
                .cand       (way_cand[w])
            );
        end
    endgenerate

    tlbx_hit_merge #(
        .NUM_WAYS (NUM_WAYS),
        .PAGE_MIN (PAGE_MIN),
        .PAGE_STEP(PAGE_STEP)
    ) u_merge (
        .hit_vec      (hit_vec),
        .way_ring     (way_ring),
        .way_cand     (way_cand),
        .any_hit      (any_hit),
        .multi_hit    (multi_hit),
        .sel_way      (sel_way),
        .sel_ring     (sel_ring),
        .sel_entry    (sel_entry),
        .sel_offs_mask(sel_offs_mask)
    );

    tlbx_perm_check u_perm (
        .any_hit  (any_hit),
        .multi_hit(multi_hit),
        .kind     (acc_kind_e'(req_kind)),
        .priv     (req_priv),
        .ring     (sel_ring),
        .entry    (sel_entry),
        .vaddr    (req_vaddr),
        .offs_mask(sel_offs_mask),
        .ok       (chk_ok),
        .cause    (chk_cause),
        .paddr    (chk_paddr),
        .perm     (chk_perm),
        .cache    (chk_cache)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
            rsp_cache <= '0;
            rsp_way   <= '0;
            rsp_ring  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_ok    <= chk_ok;
                rsp_cause <= chk_cause;
                rsp_paddr <= chk_paddr;
                rsp_perm  <= chk_perm;
                rsp_cache <= chk_cache;
                rsp_way   <= chk_ok ? sel_way : '0;
                rsp_ring  <= chk_ok ? sel_ring : '0;
            end
        end
    end

endmodule

// File: rtl/tlbx_lookup_chk.sv
module tlbx_lookup_chk
    import tlbx_pkg::*;
#(
    parameter int NUM_WAYS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                rasid_we,
    input logic                req_valid,
    input logic [1:0]          req_kind,
    input logic [NUM_WAYS-1:0] hit_vec,
    input logic [RASID_W-1:0]  rasid_q,
    input logic                rsp_valid,
    input logic                rsp_ok,
    input logic [3:0]          rsp_cause,
    input logic [2:0]          rsp_perm
);

    assert_rasid_reset_R1: assert property (@(posedge clk)
        rst |=> (rasid_q == RASID_RESET));

    assert_rasid_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rasid_we |=> $stable(rasid_q));

    assert_multi_cause_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $countones(hit_vec) > 1) |=>
            (rsp_cause == CAUSE_FETCH_MULTI || rsp_cause == CAUSE_DATA_MULTI));

    assert_miss_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit_vec == '0) |=>
            (rsp_cause == CAUSE_FETCH_MISS || rsp_cause == CAUSE_DATA_MISS));

    assert_fetch_strip_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == ACC_FETCH) |=> (rsp_perm[1:0] == 2'b00));

    assert_data_strip_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != ACC_FETCH) |=> (rsp_perm[2] == 1'b0));

    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_valid_drop_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_ok_cause_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_ok == (rsp_cause == CAUSE_NONE)));

endmodule

bind tlbx_lookup tlbx_lookup_chk #(.NUM_WAYS(NUM_WAYS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .rasid_we (rasid_we),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .hit_vec  (hit_vec),
    .rasid_q  (rasid_q),
    .rsp_valid(rsp_valid),
    .rsp_ok   (rsp_ok),
    .rsp_cause(rsp_cause),
    .rsp_perm (rsp_perm)
);

// File: tb/tlbx_lookup_tb.sv
module tlbx_lookup_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NW    = 4;
    localparam int NE    = 4;
    localparam int PMIN  = 12;
    localparam int PSTEP = 2;
    localparam int EW    = 76;
    localparam int WW    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rasid_we = 1'b0;
    logic [31:0] rasid_wdata = '0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [1:0] req_priv = '0;
    logic [31:0] req_vaddr = '0;
    logic [NW*NE*EW-1:0] tlb_flat = '0;
    logic rsp_valid, rsp_ok;
    logic [3:0] rsp_cause;
    logic [31:0] rsp_paddr;
    logic [2:0] rsp_perm, rsp_cache;
    logic [WW-1:0] rsp_way;
    logic [1:0] rsp_ring;

    int checks = 0;
    int errors = 0;

    logic [31:0] t_tag   [NW][NE];
    logic [31:0] t_pbase [NW][NE];
    logic [7:0]  t_asid  [NW][NE];
    logic [3:0]  t_attr  [NW][NE];
    logic [31:0] m_rasid = 32'h0403_0201;

    logic        e_ok;
    logic [3:0]  e_cause;
    logic [31:0] e_paddr;
    logic [2:0]  e_perm, e_cache;
    logic [1:0]  e_way, e_ring;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbx_lookup dut_i (
        .clk(clk), .rst(rst), .rasid_we(rasid_we), .rasid_wdata(rasid_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_priv(req_priv),
        .req_vaddr(req_vaddr), .tlb_entries(tlb_flat),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_cause(rsp_cause),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_cache(rsp_cache),
        .rsp_way(rsp_way), .rsp_ring(rsp_ring)
    );

    function automatic logic [31:0] offs(input int w);
        return 32'((64'd1 << (PMIN + w*PSTEP)) - 1);
    endfunction

    function automatic int idx_of(input logic [31:0] va, input int w);
        return int'((va >> (PMIN + w*PSTEP)) & 32'(NE - 1));
    endfunction

    // Expected result, derived from R1..R11.
    function automatic void model(input logic [31:0] va, input int kind, input int priv);
        int nhit, hw, hr, ring, e;
        logic [2:0] p;
        logic [2:0] cm;
        logic [3:0] a;
        logic gr;
        nhit = 0; hw = 0; hr = 0;
        for (int w = NW - 1; w >= 0; w--) begin
            e = idx_of(va, w);
            ring = -1;
            for (int r = RINGS_MAX() - 1; r >= 0; r--)
                if (m_rasid[r*8 +: 8] == t_asid[w][e]) ring = r;
            if ((((t_tag[w][e] ^ va) & ~offs(w)) == 0) && t_asid[w][e] != 0 && ring >= 0) begin
                nhit++; hw = w; hr = ring;
            end
        end
        a = t_attr[hw][idx_of(va, hw)];
        p = 3'b000; cm = 3'd0;
        if (a < 12) begin
            p = {a[0], a[1], 1'b1};
            cm = (a[3:2] == 0) ? 3'd1 : (a[3:2] == 1) ? 3'd2 : 3'd3;
        end else if (a == 13) begin
            p = 3'b011; cm = 3'd4;
        end
        if (kind == 2) p = p & 3'b100; else p = p & 3'b011;
        gr = (kind == 0) ? p[0] : (kind == 1) ? p[1] : (kind == 2) ? p[2] : 1'b0;
        if (nhit > 1) e_cause = (kind == 2) ? 4'd2 : 4'd6;
        else if (nhit == 0) e_cause = (kind == 2) ? 4'd1 : 4'd5;
        else if (hr < priv) e_cause = (kind == 2) ? 4'd3 : 4'd7;
        else if (!gr) e_cause = (kind == 2) ? 4'd4 : (kind == 1) ? 4'd9 : 4'd8;
        else e_cause = 4'd0;
        e_ok = (e_cause == 0);
        e_paddr = e_ok ? (t_pbase[hw][idx_of(va, hw)] | (va & offs(hw))) : 32'd0;
        e_perm  = e_ok ? p : 3'd0;
        e_cache = e_ok ? cm : 3'd0;
        e_way   = e_ok ? 2'(hw) : 2'd0;
        e_ring  = e_ok ? 2'(hr) : 2'd0;
    endfunction

    function automatic int RINGS_MAX();
        return 4;
    endfunction

    task automatic pack_table();
        for (int w = 0; w < NW; w++)
            for (int e = 0; e < NE; e++)
                tlb_flat[(w*NE+e)*EW +: EW] = {t_tag[w][e], t_pbase[w][e], t_asid[w][e], t_attr[w][e]};
    endtask

    task automatic clear_table();
        for (int w = 0; w < NW; w++)
            for (int e = 0; e < NE; e++) begin
                t_tag[w][e] = '0; t_pbase[w][e] = '0; t_asid[w][e] = '0; t_attr[w][e] = '0;
            end
    endtask

    task automatic put(input logic [31:0] va, input int w, input logic [7:0] asid,
                       input logic [3:0] attr, input logic [31:0] pb);
        t_tag[w][idx_of(va, w)]   = va;
        t_pbase[w][idx_of(va, w)] = pb;
        t_asid[w][idx_of(va, w)]  = asid;
        t_attr[w][idx_of(va, w)]  = attr;
    endtask

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_rasid(input logic [31:0] v);
        @(negedge clk);
        rasid_we = 1'b1; rasid_wdata = v;
        @(negedge clk);
        rasid_we = 1'b0;
        m_rasid = v;
    endtask

    task automatic lookup(input logic [31:0] va, input int kind, input int priv, input string req);
        pack_table();
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = 2'(kind); req_priv = 2'(priv);
        model(va, kind, priv);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_ok == e_ok && rsp_cause == e_cause && rsp_paddr == e_paddr &&
              rsp_perm == e_perm && rsp_cache == e_cache && rsp_way == e_way && rsp_ring == e_ring,
              req, "response {valid,ok,cause,paddr,perm,cache,way,ring}",
              {rsp_valid, rsp_ok, rsp_cause, rsp_paddr, rsp_perm, rsp_cache, rsp_way, rsp_ring},
              {1'b1, e_ok, e_cause, e_paddr, e_perm, e_cache, e_way, e_ring});
    endtask

    function automatic logic [7:0] pick_asid();
        int r;
        r = int'($urandom % 6);
        if (r == 5) return 8'($urandom);
        return 8'(r);
    endfunction

    task automatic random_lookup(input string req);
        logic [31:0] va;
        va = $urandom;
        for (int w = 0; w < NW; w++)
            for (int e = 0; e < NE; e++) begin
                t_tag[w][e] = $urandom; t_pbase[w][e] = $urandom;
                t_asid[w][e] = pick_asid(); t_attr[w][e] = 4'($urandom);
            end
        for (int w = 0; w < NW; w++)
            if ($urandom % 2 == 1) t_tag[w][idx_of(va, w)] = va ^ ($urandom & offs(w));
        lookup(va, int'($urandom % 4), int'($urandom % 4), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] va;
        void'($urandom(32'd20240611));
        clear_table();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !rsp_ok && rsp_cause == 0, "R11", "reset outputs",
              {rsp_valid, rsp_ok, rsp_cause}, 0);

        // R1: reset identifiers map to rings 0..3
        va = 32'h0001_2345;
        clear_table(); put(va, 0, 8'd4, 4'd5, 32'h8000_0000);
        lookup(va, 0, 0, "R1");
        check(rsp_ring == 2'd3, "R1", "ring of identifier 4", rsp_ring, 3);
        clear_table(); put(va, 1, 8'd1, 4'd5, 32'h8000_0000);
        lookup(va, 0, 3, "R1");
        check(rsp_ring == 2'd0, "R1", "ring of identifier 1", rsp_ring, 0);

        // R2: duplicate bytes, lowest position wins
        write_rasid(32'h0907_0705);
        clear_table(); put(va, 2, 8'd7, 4'd4, 32'h0100_0000);
        lookup(va, 0, 0, "R2");
        check(rsp_ring == 2'd1, "R2", "lowest duplicate ring", rsp_ring, 1);
        // R2: same-cycle write uses old value
        clear_table(); put(va, 0, 8'd9, 4'd4, 32'h0);
        pack_table();
        @(negedge clk);
        rasid_we = 1'b1; rasid_wdata = 32'h0403_0201;
        req_valid = 1'b1; req_vaddr = va; req_kind = 2'd0; req_priv = 2'd0;
        model(va, 0, 0);
        @(negedge clk);
        rasid_we = 1'b0; req_valid = 1'b0; m_rasid = 32'h0403_0201;
        check(rsp_ok && rsp_ring == 2'd3, "R2", "same-cycle write sees old ring register",
              {rsp_ok, rsp_ring}, {1'b1, 2'd3});
        lookup(va, 0, 0, "R2");

        // R3: zero identifier and unmatched identifier never hit
        write_rasid(32'h0403_0200);
        clear_table(); put(va, 1, 8'd0, 4'd3, 32'h0);
        lookup(va, 0, 0, "R3");
        check(rsp_cause == 4'd5, "R3", "zero identifier misses", rsp_cause, 5);
        write_rasid(32'h0403_0201);
        clear_table(); put(va, 1, 8'd9, 4'd3, 32'h0);
        lookup(va, 2, 0, "R3");

        // R4: multi-hit beats privilege
        clear_table(); put(va, 0, 8'd1, 4'd3, 32'h0); put(va, 3, 8'd2, 4'd3, 32'h0);
        lookup(va, 1, 3, "R4");
        check(rsp_cause == 4'd6, "R4", "data multi-hit", rsp_cause, 6);
        lookup(va, 2, 3, "R4");
        check(rsp_cause == 4'd2, "R4", "fetch multi-hit", rsp_cause, 2);

        // R5: miss
        clear_table();
        lookup(va, 0, 0, "R5");
        lookup(va, 2, 0, "R5");

        // R6: privilege
        clear_table(); put(va, 2, 8'd2, 4'd3, 32'h0);
        lookup(va, 0, 2, "R6");
        check(rsp_cause == 4'd7, "R6", "data privilege", rsp_cause, 7);
        lookup(va, 2, 2, "R6");
        lookup(va, 0, 1, "R6");

        // R7: attribute decode
        clear_table(); put(va, 0, 8'd1, 4'd13, 32'h0);
        lookup(va, 0, 0, "R7");
        check(rsp_cache == 3'd4 && rsp_perm == 3'b011, "R7", "isolate",
              {rsp_cache, rsp_perm}, {3'd4, 3'b011});
        clear_table(); put(va, 0, 8'd1, 4'd10, 32'h0);
        lookup(va, 1, 0, "R7");
        clear_table(); put(va, 0, 8'd1, 4'd1, 32'h0);
        lookup(va, 2, 0, "R7");

        // R8: kind strips permissions
        clear_table(); put(va, 1, 8'd1, 4'd3, 32'h0);
        lookup(va, 2, 0, "R8");
        check(rsp_perm == 3'b100, "R8", "fetch perm", rsp_perm, 3'b100);
        lookup(va, 0, 0, "R8");
        check(rsp_perm == 3'b011, "R8", "data perm", rsp_perm, 3'b011);

        // R9: denial causes
        clear_table(); put(va, 1, 8'd1, 4'd12, 32'h0);
        lookup(va, 0, 0, "R9");
        clear_table(); put(va, 1, 8'd1, 4'd9, 32'h0);
        lookup(va, 1, 0, "R9");
        check(rsp_cause == 4'd9, "R9", "store denied", rsp_cause, 9);
        clear_table(); put(va, 1, 8'd1, 4'd0, 32'h0);
        lookup(va, 2, 0, "R9");
        clear_table(); put(va, 1, 8'd1, 4'd3, 32'h0);
        lookup(va, 3, 0, "R9");

        // R10: widest way keeps 18 offset bits
        va = 32'hABCD_E123;
        clear_table(); put(va, 3, 8'd3, 4'd7, 32'h5000_0000);
        lookup(va, 0, 0, "R10");
        check(rsp_paddr == (32'h5000_0000 | (va & 32'h0003_FFFF)), "R10", "paddr way 3",
              rsp_paddr, 32'h5000_0000 | (va & 32'h0003_FFFF));

        // R11: valid drops when no request
        @(negedge clk);
        check(!rsp_valid, "R11", "valid drops", rsp_valid, 0);

        // Random phase, reset ring register
        for (int i = 0; i < 300; i++) random_lookup("R4/R5/R6/R7/R8/R9/R10 random");
        // Random phase, random ring registers with repeats and zeros
        for (int j = 0; j < 15; j++) begin
            write_rasid({8'($urandom % 7), 8'($urandom % 7), 8'($urandom % 7), 8'($urandom % 7)});
            for (int i = 0; i < 20; i++) random_lookup("R2/R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule